// File: doc/BRIEF.md
# Dual-Port Pixel Output Formatter

This block sits between a pixel source and a pair of wide output ports. Each cycle where the input valid flag is high, it takes one RGB pixel. It then places the pixel on output port A, or on ports A and B, according to an 8-bit control word held in the block. There are two rates:

- **Half-rate mode:** two consecutive pixels are gathered and released together. This gives one output strobe for every two input pixels.
- **Full-rate mode:** every pixel goes straight out on port A, and port B is parked at a constant level.

The same control word also governs three output conditions:

- **Polarity:** data leaves either as-is or bitwise complemented.
- **Forced level:** both ports can be forced to a fixed level.
- **Output enable:** each port has its own output-enable line, which a pad ring uses to float the pins.

The polarity bit does double duty. When it is 1, data passes as-is and every constant level (the parked port B and the forced level) is all ones. When it is 0, data is complemented and those constants are all zeros. The low four control bits control nothing inside the block. They are stored, read back and passed straight out to neighbouring logic.

Top module: `pix_out_fmt`

## Requirements
- R1: While reset is asserted and right after it is released, the control word reads 0x20, both output-enable lines are low and the output strobe is low.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the control word at the clock edge, and `cfg_rdata` shows the new word from the next cycle. The bit positions are: bit 7 enable, bit 6 full-rate select, bit 5 polarity (1 = as-is), bit 4 force.
- R3: `port_a_oe` and `port_b_oe` both follow control bit 7. When bit 7 is 0 both are low, whatever the force bit says.
- R4: With bit 6 at 0, every second accepted pixel causes a one-cycle strobe in the next cycle. At that strobe, port A carries the earlier pixel of the pair and port B carries the later one.
- R5: With bit 6 at 1, every accepted pixel appears on port A in the next cycle, together with a one-cycle strobe.
- R6: With bit 6 at 1 and bit 4 at 0, every bit of port B equals bit 5.
- R7: With bit 5 at 0, the pixel data on the ports is the bitwise complement of the input. With bit 5 at 1, it is unchanged.
- R8: With bit 4 at 1, every bit of both ports equals bit 5, whatever the mode or the data.
- R9: A write that changes bit 6 discards any half-formed pair, so the next accepted pixel becomes the first pixel of a new pair.
- R10: Control bits 3 down to 0 appear on `aux_ctrl` and have no effect on the ports or the strobe.
- R11: Between strobes, the ports keep the last pixels that were emitted. A change to bit 4 or bit 5 takes effect on the ports in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Current control word |
| pix_valid | input | 1 | Input pixel present this cycle |
| pix_data | input | PIX_W | Input pixel |
| port_a | output | PIX_W | Output port A data |
| port_b | output | PIX_W | Output port B data |
| port_a_oe | output | 1 | Port A output-enable (tri-state control) |
| port_b_oe | output | 1 | Port B output-enable (tri-state control) |
| out_strobe | output | 1 | One-cycle pulse marking newly emitted output data |
| aux_ctrl | output | 4 | Pass-through of control bits 3..0 |

## Verification
The bench builds the block with its default 24-bit pixel width and the 0x20 reset word. At 24 bits, the complement and parked-constant patterns are unmistakable across the full width, and the reset defaults tested are the ones that really ship. A behavioural model keeps the half-formed pair in a queue. This makes it possible to reach odd pixel counts, gaps between the two pixels of a pair, mode flips in the middle of a pair and polarity changes while data is being held. In the random phase, polarity, force and enable combinations come in any order.

// File: rtl/pof_pkg.sv
package pof_pkg;

   localparam int CTRL_W    = 8;
   localparam int AUX_W     = 4;
   localparam int OE_BIT    = 7;
   localparam int MODE_BIT  = 6;
   localparam int PASS_BIT  = 5;
   localparam int FORCE_BIT = 4;
   localparam int NPORT     = 2;

   // Field order follows the control word bit order, MSB first.
   typedef struct packed {
      logic             oe;
      logic             full_rate;
      logic             pass;
      logic             force_lvl;
      logic [AUX_W-1:0] aux;
   } ctrl_t;

endpackage

// File: rtl/pof_ctrl_reg.sv
module pof_ctrl_reg
   import pof_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RESET_VAL = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTRL_W-1:0] wdata,
   output ctrl_t             ctrl,
   output logic              mode_flip
);

   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_t'(RESET_VAL);
      end else if (we) begin
         ctrl_q <= ctrl_t'(wdata);
      end
   end

   assign ctrl      = ctrl_q;
   // A write that toggles the rate select restarts the pairing.
   assign mode_flip = we & (wdata[MODE_BIT] != ctrl_q.full_rate);

endmodule

// File: rtl/pof_pair_unit.sv
module pof_pair_unit #(
   parameter int PIX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             full_rate,
   input  logic             restart,
   output logic [PIX_W-1:0] raw_a,
   output logic [PIX_W-1:0] raw_b,
   output logic             emit
);

   logic             have_first;
   logic [PIX_W-1:0] first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_first <= 1'b0;
         first_q    <= '0;
         raw_a      <= '0;
         raw_b      <= '0;
         emit       <= 1'b0;
      end else begin
         emit <= 1'b0;
         if (pix_valid) begin
            if (full_rate) begin
               raw_a <= pix_data;
               emit  <= 1'b1;
            end else if (have_first) begin
               raw_a      <= first_q;
               raw_b      <= pix_data;
               emit       <= 1'b1;
               have_first <= 1'b0;
            end else begin
               first_q    <= pix_data;
               have_first <= 1'b1;
            end
         end
         if (restart) begin
            have_first <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pof_out_drive.sv
module pof_out_drive #(
   parameter int PIX_W = 24,
   parameter int NPORT = 2
) (
   input  logic                        oe,
   input  logic                        full_rate,
   input  logic                        pass,
   input  logic                        force_lvl,
   input  logic [NPORT-1:0][PIX_W-1:0] raw,
   output logic [NPORT-1:0][PIX_W-1:0] dout,
   output logic [NPORT-1:0]            dout_oe
);

   localparam logic [PIX_W-1:0] ONES = {PIX_W{1'b1}};

   logic [PIX_W-1:0] level;
   assign level = pass ? ONES : '0;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      // Port 0 is the primary lane; all others park in full-rate mode.
      localparam bit SECONDARY = (p != 0);
      logic park;
      if (SECONDARY) begin : g_sec
         assign park = force_lvl | full_rate;
      end else begin : g_pri
         assign park = force_lvl;
      end
      assign dout[p]    = park ? level : (pass ? raw[p] : ~raw[p]);
      assign dout_oe[p] = oe;
   end

endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt
   import pof_pkg::*;
#(
   parameter int                PIX_W     = 24,
   parameter logic [CTRL_W-1:0] RESET_VAL = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] cfg_rdata,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic [PIX_W-1:0]  port_a,
   output logic [PIX_W-1:0]  port_b,
   output logic              port_a_oe,
   output logic              port_b_oe,
   output logic              out_strobe,
   output logic [AUX_W-1:0]  aux_ctrl
);

   if (PIX_W < 1) begin : g_bad_width
      $error("pix_out_fmt: PIX_W must be at least 1");
   end
   if (NPORT != 2) begin : g_bad_ports
      $error("pix_out_fmt: exactly two output ports are supported");
   end

   ctrl_t                       ctrl;
   logic                        mode_flip;
   logic [PIX_W-1:0]            raw_a;
   logic [PIX_W-1:0]            raw_b;
   logic [NPORT-1:0][PIX_W-1:0] raw_bus;
   logic [NPORT-1:0][PIX_W-1:0] out_bus;
   logic [NPORT-1:0]            oe_bus;

   pof_ctrl_reg #(.RESET_VAL(RESET_VAL)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wdata     (cfg_wdata),
      .ctrl      (ctrl),
      .mode_flip (mode_flip)
   );

   pof_pair_unit #(.PIX_W(PIX_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .pix_valid (pix_valid),
      .pix_data  (pix_data),
      .full_rate (ctrl.full_rate),
      .restart   (mode_flip),
      .raw_a     (raw_a),
      .raw_b     (raw_b),
      .emit      (out_strobe)
   );

   assign raw_bus[0] = raw_a;
   assign raw_bus[1] = raw_b;

   pof_out_drive #(.PIX_W(PIX_W), .NPORT(NPORT)) u_drive (
      .oe        (ctrl.oe),
      .full_rate (ctrl.full_rate),
      .pass      (ctrl.pass),
      .force_lvl (ctrl.force_lvl),
      .raw       (raw_bus),
      .dout      (out_bus),
      .dout_oe   (oe_bus)
   );

   assign port_a    = out_bus[0];
   assign port_b    = out_bus[1];
   assign port_a_oe = oe_bus[0];
   assign port_b_oe = oe_bus[1];
   assign cfg_rdata = ctrl;
   assign aux_ctrl  = ctrl.aux;

endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
   parameter int         PIX_W     = 24,
   parameter logic [7:0] RESET_VAL = 8'h20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [7:0]       cfg_wdata,
   input logic [7:0]       cfg_rdata,
   input logic             pix_valid,
   input logic [PIX_W-1:0] port_a,
   input logic [PIX_W-1:0] port_b,
   input logic             port_a_oe,
   input logic             port_b_oe,
   input logic             out_strobe,
   input logic [3:0]       aux_ctrl
);

   // R1
   reset_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_rdata == RESET_VAL && !out_strobe));

   // R3
   oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (port_a_oe == $past(cfg_wdata[7]) && port_b_oe == $past(cfg_wdata[7])));

   // R4
   half_no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rdata[6] && out_strobe) |=> !out_strobe);

   // R5
   full_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[6] && pix_valid) |=> out_strobe);

   // R6
   park_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[6] |-> (port_b == {PIX_W{cfg_rdata[5]}}));

   // R8
   force_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[4] |-> (port_a == {PIX_W{cfg_rdata[5]}} && port_b == {PIX_W{cfg_rdata[5]}}));

   // R10
   aux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (aux_ctrl == $past(cfg_wdata[3:0])));

endmodule

bind pix_out_fmt pof_checker #(.PIX_W(PIX_W), .RESET_VAL(RESET_VAL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .pix_valid  (pix_valid),
   .port_a     (port_a),
   .port_b     (port_b),
   .port_a_oe  (port_a_oe),
   .port_b_oe  (port_b_oe),
   .out_strobe (out_strobe),
   .aux_ctrl   (aux_ctrl)
);

// File: tb/tb_pix_out_fmt.sv
module tb_pix_out_fmt;

   localparam int CLK_PERIOD = 10;
   localparam int PW         = 24;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [7:0]    cfg_wdata = '0;
   logic [7:0]    cfg_rdata;
   logic          pix_valid = 1'b0;
   logic [PW-1:0] pix_data = '0;
   logic [PW-1:0] port_a, port_b;
   logic          port_a_oe, port_b_oe, out_strobe;
   logic [3:0]    aux_ctrl;

   pix_out_fmt #(.PIX_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pix_valid(pix_valid), .pix_data(pix_data),
      .port_a(port_a), .port_b(port_b), .port_a_oe(port_a_oe),
      .port_b_oe(port_b_oe), .out_strobe(out_strobe), .aux_ctrl(aux_ctrl)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;

   // Behavioural reference model
   logic [7:0]    m_ctrl;
   logic [PW-1:0] m_a, m_b;
   logic          m_strobe;
   logic [PW-1:0] pend[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ctrl   = 8'h20;
         m_a      = '0;
         m_b      = '0;
         m_strobe = 1'b0;
         pend.delete();
      end else begin
         m_strobe = 1'b0;
         if (pix_valid) begin
            if (m_ctrl[6]) begin
               m_a = pix_data;
               m_strobe = 1'b1;
            end else if (pend.size() == 1) begin
               m_a = pend.pop_front();
               m_b = pix_data;
               m_strobe = 1'b1;
            end else begin
               pend.push_back(pix_data);
            end
         end
         if (cfg_we) begin
            if (cfg_wdata[6] != m_ctrl[6]) pend.delete();
            m_ctrl = cfg_wdata;
         end
      end
   end

   task automatic chk(string req, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic compare_all();
      logic [PW-1:0] k, ea, eb;
      string ta, tb_, ts;
      k  = {PW{m_ctrl[5]}};
      ea = m_ctrl[4] ? k : (m_ctrl[5] ? m_a : ~m_a);
      eb = (m_ctrl[4] || m_ctrl[6]) ? k : (m_ctrl[5] ? m_b : ~m_b);
      ta  = m_ctrl[4] ? "R8" : (!m_ctrl[5] ? "R7" : (m_ctrl[6] ? "R5" : "R4"));
      tb_ = m_ctrl[4] ? "R8" : (m_ctrl[6] ? "R6" : (!m_ctrl[5] ? "R7" : "R4"));
      ts  = m_ctrl[6] ? "R5" : "R4";
      chk("R2", "cfg_rdata", PW'(cfg_rdata), PW'(m_ctrl));
      chk("R3", "port_a_oe", PW'(port_a_oe), PW'(m_ctrl[7]));
      chk("R3", "port_b_oe", PW'(port_b_oe), PW'(m_ctrl[7]));
      chk(ts, "out_strobe", PW'(out_strobe), PW'(m_strobe));
      chk(ta, "port_a", port_a, ea);
      chk(tb_, "port_b", port_b, eb);
      chk("R10", "aux_ctrl", PW'(aux_ctrl), PW'(m_ctrl[3:0]));
   endtask

   // Compare at the falling edge, then drive the next cycle's inputs.
   task automatic tick(logic we, logic [7:0] wd, logic pv, logic [PW-1:0] pd);
      @(negedge clk);
      compare_all();
      cfg_we    = we;
      cfg_wdata = wd;
      pix_valid = pv;
      pix_data  = pd;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 1'b0, '0);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         n_bad++;
         $display("FAIL R1 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
         summary();
         $finish;
      end
   end

   initial begin
      logic [PW-1:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state, still in reset
      chk("R1", "cfg_rdata in reset", PW'(cfg_rdata), PW'(8'h20));
      chk("R1", "oe in reset", PW'({port_a_oe, port_b_oe}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "cfg_rdata after reset", PW'(cfg_rdata), PW'(8'h20));
      chk("R1", "strobe after reset", PW'(out_strobe), '0);

      // R2 R3 R4: enable, half rate, data as-is
      tick(1'b1, 8'hA0, 1'b0, '0);
      for (int i = 1; i <= 6; i++) tick(1'b0, 8'h00, 1'b1, PW'(24'h100000 * i + i));
      tick(1'b0, 8'h00, 1'b1, 24'hABCDEF);
      idle(2);
      tick(1'b0, 8'h00, 1'b1, 24'h123456);
      idle(1);
      // R4: pair check directed at the strobe cycle
      chk("R4", "pair earlier on A", port_a, 24'hABCDEF);
      chk("R4", "pair later on B", port_b, 24'h123456);
      held = port_a;
      idle(3);
      // R11: hold between strobes
      chk("R11", "port_a held", port_a, held);

      // R7 R11: complement takes effect after the write
      tick(1'b1, 8'h80, 1'b0, '0);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R11", "port_a complemented after write", port_a, ~held);
      tick(1'b0, 8'h00, 1'b1, 24'h0F0F0F);
      tick(1'b0, 8'h00, 1'b1, 24'h00FF00);
      idle(2);

      // R5 R6: full rate, both polarities
      tick(1'b1, 8'hE0, 1'b0, '0);
      for (int i = 0; i < 5; i++) tick(1'b0, 8'h00, 1'b1, PW'(24'hC0FFEE ^ i));
      tick(1'b1, 8'hC0, 1'b1, 24'h5A5A5A);
      for (int i = 0; i < 4; i++) tick(1'b0, 8'h00, i[0], PW'(24'h3C0000 + i));
      idle(1);
      chk("R6", "port_b parked low", port_b, '0);

      // R8: force high and low, R3: disabled wins over force
      tick(1'b1, 8'hB0, 1'b1, 24'h111111);
      tick(1'b0, 8'h00, 1'b1, 24'h222222);
      tick(1'b1, 8'hD0, 1'b1, 24'h333333);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R8", "forced low", port_a, '0);
      tick(1'b1, 8'h70, 1'b0, '0);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R3", "oe low while forced", PW'({port_a_oe, port_b_oe}), '0);

      // R9: mode flip discards half pair
      tick(1'b1, 8'hA0, 1'b0, '0);
      tick(1'b0, 8'h00, 1'b1, 24'hAAAAAA);
      tick(1'b1, 8'hE0, 1'b0, '0);
      tick(1'b1, 8'hA0, 1'b0, '0);
      tick(1'b0, 8'h00, 1'b1, 24'hBBBBBB);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R9", "no strobe after first pixel of new pair", PW'(out_strobe), '0);
      tick(1'b0, 8'h00, 1'b1, 24'hCCCCCC);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R9", "strobe after second pixel", PW'(out_strobe), PW'(1));
      chk("R9", "new pair first on A", port_a, 24'hBBBBBB);

      // R10: aux bits pass through and leave data alone
      tick(1'b1, 8'hAF, 1'b1, 24'h010203);
      tick(1'b0, 8'h00, 1'b1, 24'h040506);
      tick(1'b0, 8'h00, 1'b0, '0);
      chk("R10", "aux value", PW'(aux_ctrl), PW'(4'hF));
      chk("R10", "data unaffected by aux", port_b, 24'h040506);
      tick(1'b1, 8'hE5, 1'b1, 24'h0A0B0C);
      idle(2);

      // Random mix of modes, polarity, force, enable and traffic
      for (int i = 0; i < 3000; i++) begin
         logic we;
         we = ($urandom_range(0, 15) == 0);
         tick(we, 8'($urandom), ($urandom_range(0, 3) != 0), PW'($urandom));
      end
      idle(2);
      summary();
      $finish;
   end

endmodule